// File: doc/BRIEF.md
# AC97 Controller Frame Timing Generator

This block is the controller end of a five-wire AC97-style serial audio link. The codec supplies the bit clock. On that clock the block counts out fixed frames of 256 bits. Each frame holds 13 slots: a 16-bit tag slot followed by twelve 20-bit data slots. The block drives the frame sync high for the whole tag slot and shifts the playback words out on the serial output line, most significant bit first. On the falling bit-clock edge it samples the capture line into a shift register.

At the first bit-clock cycle after the last bit of slot 12, the block raises `frameDone` for one cycle. In that same cycle it copies the captured frame into holding registers, which keep their value for the whole of the next frame. The playback words are read from the parallel inputs once per frame, at the edge that starts the tag slot. The parallel side may therefore change them at any later point in the frame. The block also drives the active-low codec reset line. While a codec reset is requested, the sync and data lines stay quiet.

Top module: `ac97_frame_gen`

## Requirements
- R1: A frame is 256 bit clocks long. `frameSync` is high during bits 0 to 15 of every frame and low during bits 16 to 255.
- R2: `sdataOut` carries the 256-bit word {txTag, txData} most significant bit first, one bit per bit clock, updated on the rising edge. Bit k of the frame is word bit 255-k, so slot 1 is txData[239:220] and slot 12 is txData[19:0].
- R3: `txTag` and `txData` are sampled only at the rising edge that starts bit 0. Changes made later in the frame do not affect that frame's output.
- R4: `sdataIn` is sampled on the falling edge during bit k and stored at position 255-k of {rxTag, rxData}.
- R5: `frameDone` is high for exactly one cycle, in bit 0 of the following frame. `rxTag` and `rxData` update in that cycle and are held until the next pulse.
- R6: While `rstN` is low, `codecResetN`, `frameSync`, `sdataOut` and `frameDone` are low. The first rising edge after release starts bit 0 of a frame, with `codecResetN` high and no `frameDone`.
- R7: While `codecResetReq` is high, from the next rising edge on, `codecResetN`, `frameSync`, `sdataOut` and `frameDone` are low. The rising edge after the request drops starts bit 0 of a new frame, and the aborted frame produces no `frameDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock supplied by the codec |
| rstN | input | 1 | Asynchronous active-low block reset |
| codecResetReq | input | 1 | Request to hold the codec in reset |
| txTag | input | 16 | Outgoing tag slot word |
| txData | input | 240 | Outgoing data slots 1 to 12, slot 1 in the top bits |
| sdataIn | input | 1 | Serial capture data from the codec |
| frameSync | output | 1 | Frame sync, high during the tag slot |
| sdataOut | output | 1 | Serial playback data to the codec |
| codecResetN | output | 1 | Active-low codec reset |
| rxTag | output | 16 | Captured tag slot of the last complete frame |
| rxData | output | 240 | Captured data slots 1 to 12 of the last complete frame |
| frameDone | output | 1 | One-cycle pulse when a captured frame becomes valid |

## Verification
Serial outputs are due one register after the rising edge that opens their bit. The bench samples them 2 ns after each rising edge. It drives the capture bit at the same moment, so the bit is stable at the falling edge 2 ns later. `frameDone` and the captured words are due one cycle after the last capture bit, so they are checked in bit 0 of the next frame and again mid-frame to confirm they hold. The codec-reset response is due one rising edge after the request, which is where the quiet-line checks start.

// File: rtl/ac97_frame_pkg.sv
package ac97_frame_pkg;
  // strobes from the frame sequencer to the shift datapath
  typedef struct packed {
    logic clear;    // empty the playback shifter
    logic load;     // take a new playback frame
    logic shift;    // advance playback by one bit
    logic capture;  // copy the capture shifter to the hold registers
  } frameStrobe_t;
endpackage

// File: rtl/ac97_frame_ctrl.sv
module ac97_frame_ctrl
  import ac97_frame_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int SLOTS     = 13,
  localparam int FRAME_BITS = TAG_BITS + (SLOTS - 1) * SLOT_BITS,
  localparam int CNT_W      = $clog2(FRAME_BITS)
) (
  input  logic         bitClk,
  input  logic         rstN,
  input  logic         resetReq,
  output frameStrobe_t stb,
  output logic         frameSync,
  output logic         frameDone,
  output logic         codecResetN
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_BITS);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             running;

  assign nextCnt = (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      bitCnt      <= LAST_BIT;
      running     <= 1'b0;
      frameSync   <= 1'b0;
      frameDone   <= 1'b0;
      codecResetN <= 1'b0;
    end else begin
      codecResetN <= ~resetReq;
      if (resetReq) begin
        bitCnt    <= LAST_BIT;
        running   <= 1'b0;
        frameSync <= 1'b0;
        frameDone <= 1'b0;
      end else begin
        bitCnt    <= nextCnt;
        running   <= 1'b1;
        frameSync <= (nextCnt < TAG_END);
        frameDone <= running && (bitCnt == LAST_BIT);
      end
    end
  end

  always_comb begin
    stb.clear   = resetReq;
    stb.load    = !resetReq && (nextCnt == '0);
    stb.shift   = !resetReq && (nextCnt != '0);
    stb.capture = !resetReq && running && (bitCnt == LAST_BIT);
  end

  // R5: the done pulse never lasts longer than one cycle
  a_r5_done_pulse: assert property (@(posedge bitClk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R5: the pulse lands in the first bit of the following frame
  a_r5_done_at_wrap: assert property (@(posedge bitClk) disable iff (!rstN)
    frameDone |-> bitCnt == '0);

  // R1: sync drops exactly when the first data slot begins
  a_r1_sync_width: assert property (@(posedge bitClk) disable iff (!rstN)
    ($fell(frameSync) && !$past(resetReq)) |-> bitCnt == TAG_END);

  // R7: a codec reset request silences the link on the next edge
  a_r7_link_quiet: assert property (@(posedge bitClk) disable iff (!rstN)
    resetReq |=> (!frameSync && !codecResetN && !frameDone));
endmodule

// File: rtl/ac97_frame_dp.sv
module ac97_frame_dp
  import ac97_frame_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int SLOTS     = 13,
  localparam int DATA_BITS  = (SLOTS - 1) * SLOT_BITS,
  localparam int FRAME_BITS = TAG_BITS + DATA_BITS
) (
  input  logic                 bitClk,
  input  logic                 rstN,
  input  frameStrobe_t         stb,
  input  logic [TAG_BITS-1:0]  txTag,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 sdataIn,
  output logic                 sdataOut,
  output logic [TAG_BITS-1:0]  rxTag,
  output logic [DATA_BITS-1:0] rxData
);
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] rxShift;
  logic [FRAME_BITS-1:0] rxHold;

  // playback: the head of the shifter is the bit on the line
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)            txShift <= '0;
    else if (stb.clear)   txShift <= '0;
    else if (stb.load)    txShift <= {txTag, txData};
    else if (stb.shift)   txShift <= txShift << 1;
  end

  assign sdataOut = txShift[FRAME_BITS-1];

  // capture: sampled mid-bit on the falling edge
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else       rxShift <= {rxShift[FRAME_BITS-2:0], sdataIn};
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN)            rxHold <= '0;
    else if (stb.capture) rxHold <= rxShift;
  end

  assign rxTag  = rxHold[FRAME_BITS-1 -: TAG_BITS];
  assign rxData = rxHold[DATA_BITS-1:0];

  // R5: captured words only move on a capture strobe
  a_r5_rx_hold: assert property (@(posedge bitClk) disable iff (!rstN)
    !stb.capture |=> $stable(rxHold));

  // R7: the playback line is low after a clear strobe
  a_r7_out_quiet: assert property (@(posedge bitClk) disable iff (!rstN)
    stb.clear |=> !sdataOut);
endmodule

// File: rtl/ac97_frame_gen.sv
module ac97_frame_gen
  import ac97_frame_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int SLOTS     = 13,
  localparam int DATA_BITS = (SLOTS - 1) * SLOT_BITS
) (
  input  logic                 bitClk,
  input  logic                 rstN,
  input  logic                 codecResetReq,
  input  logic [TAG_BITS-1:0]  txTag,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 sdataIn,
  output logic                 frameSync,
  output logic                 sdataOut,
  output logic                 codecResetN,
  output logic [TAG_BITS-1:0]  rxTag,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 frameDone
);
  frameStrobe_t stb;

  ac97_frame_ctrl #(.TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_ctrl (
    .bitClk(bitClk), .rstN(rstN), .resetReq(codecResetReq), .stb(stb),
    .frameSync(frameSync), .frameDone(frameDone), .codecResetN(codecResetN));

  ac97_frame_dp #(.TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_dp (
    .bitClk(bitClk), .rstN(rstN), .stb(stb), .txTag(txTag), .txData(txData),
    .sdataIn(sdataIn), .sdataOut(sdataOut), .rxTag(rxTag), .rxData(rxData));
endmodule

// File: tb/ac97_frame_gen_test.sv
module ac97_frame_gen_test;
  localparam int FB = 256;

  logic         bitClk = 1'b0;
  logic         rstN = 1'b0;
  logic         codecResetReq = 1'b0;
  logic [15:0]  txTag = '0;
  logic [239:0] txData = '0;
  logic         sdataIn = 1'b0;
  logic         frameSync, sdataOut, codecResetN, frameDone;
  logic [15:0]  rxTag;
  logic [239:0] rxData;

  int tests = 0;
  int fails = 0;

  ac97_frame_gen uut (
    .bitClk(bitClk), .rstN(rstN), .codecResetReq(codecResetReq),
    .txTag(txTag), .txData(txData), .sdataIn(sdataIn),
    .frameSync(frameSync), .sdataOut(sdataOut), .codecResetN(codecResetN),
    .rxTag(rxTag), .rxData(rxData), .frameDone(frameDone));

  always #4 bitClk = ~bitClk;

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [255:0] slotFrame(input logic [15:0] tag, input logic [19:0] base,
                                             input logic [19:0] step);
    logic [255:0] f;
    f[255:240] = tag;
    for (int s = 0; s < 12; s++) f[239 - 20*s -: 20] = base + step * 20'(s);
    return f;
  endfunction

  // one full frame: checks every bit, drives capture bits, switches tx at bit 10
  task automatic runFrame(input logic [255:0] tx, input logic [255:0] rx,
                          input bit expDone, input logic [255:0] prevRx,
                          input logic [255:0] nextTx);
    for (int k = 0; k < FB; k++) begin
      @(posedge bitClk); #2;
      if (k == 0) begin
        check("R5 frameDone at bit0", 256'(frameDone), 256'(expDone));
        check("R6 codecResetN high", 256'(codecResetN), 256'd1);
        if (expDone) check("R4 captured frame", {rxTag, rxData}, prevRx);
      end
      if (k == 1) check("R5 single pulse", 256'(frameDone), 256'd0);
      if (k == 128 && expDone) check("R5 capture held", {rxTag, rxData}, prevRx);
      check(k < 16 ? "R1 sync in tag" : "R1 sync low", 256'(frameSync), 256'(k < 16));
      check(k > 10 ? "R3 sdataOut after input change" : "R2 sdataOut bit",
            256'(sdataOut), 256'(tx[255-k]));
      sdataIn = rx[255-k];
      if (k == 10) {txTag, txData} = nextTx;
    end
  endtask

  task automatic resetDuring(input logic [255:0] prevRx);
    @(posedge bitClk); #2;
    check("R5 frameDone before codec reset", 256'(frameDone), 256'd1);
    check("R4 captured before codec reset", {rxTag, rxData}, prevRx);
    for (int k = 0; k < 40; k++) begin
      if (k == 5) codecResetReq = 1'b1;
      @(posedge bitClk); #2;
      if (k >= 5) begin
        check("R7 codecResetN low", 256'(codecResetN), 256'd0);
        check("R7 sync low", 256'(frameSync), 256'd0);
        check("R7 sdataOut low", 256'(sdataOut), 256'd0);
        check("R7 no frameDone", 256'(frameDone), 256'd0);
      end
    end
    codecResetReq = 1'b0;
  endtask

  task automatic resetState();
    for (int k = 0; k < 4; k++) begin
      @(posedge bitClk); #2;
      check("R6 codecResetN in reset", 256'(codecResetN), 256'd0);
      check("R6 sync in reset", 256'(frameSync), 256'd0);
      check("R6 sdataOut in reset", 256'(sdataOut), 256'd0);
      check("R6 frameDone in reset", 256'(frameDone), 256'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [255:0] fa, fb, fc, ra, rb, rc;
    fa = slotFrame(16'h9C35, 20'hA5C3E, 20'h0);
    fb = slotFrame(16'hF800, 20'h00001, 20'h11111);
    fc = {256{1'b1}};
    ra = slotFrame(16'h3A6B, 20'h5F0A1, 20'h0F0F3);
    rb = {256{1'b0}} | 256'h1;
    rc = {128{2'b10}};
    {txTag, txData} = fa;
    resetState();
    @(negedge bitClk);
    rstN = 1'b1;
    runFrame(fa, ra, 1'b0, '0, fb);
    runFrame(fb, rb, 1'b1, ra, fc);
    runFrame(fc, rc, 1'b1, rb, fa);
    resetDuring(rc);
    runFrame(fa, ra, 1'b0, '0, fb);
    runFrame(fb, rb, 1'b1, ra, fb);
    @(posedge bitClk); #2;
    check("R5 final frameDone", 256'(frameDone), 256'd1);
    check("R4 final capture", {rxTag, rxData}, rb);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule